// File: doc/BRIEF.md
# Response Data Bus Arbiter with Refusal Handshake

This block owns the response half of a split-transaction bus. Any of several responders (caches or memory) raises an intent line together with the tag of the outstanding request it wants to answer. The arbiter picks one responder and asks the original requester, identified by that tag, whether it can take the data. If the requester answers ready, the chosen responder's data goes onto the bus for a fixed number of beats. The other caches use the same cycles to present their snoop results for that tag. One cycle after the last beat, a release pulse tells every cache to free the tag's table entry.

If the requester answers with a refusal (NACK) because its receive buffer is full, the transfer is dropped without any data beat. The refused responder gets a one-cycle retry pulse and has to arbitrate again. For the next arbitration round only, it is ranked below every other responder, so that a requester that keeps refusing cannot starve the rest. The arbiter works without reference to request-side arbitration, so both sides of the bus can run at the same time.

Top module: `resp_data_arbiter`

## Requirements
- R1: Each responder presents a 3-bit tag with its intent line, in lane i (bits 3i+2..3i) of `intent_tag`. When the arbiter is idle and sees any intent, the grant and `ask_valid` rise in the next cycle. `ask_tag` then carries the granted responder's tag.
- R2: `grant` is one-hot or zero. Bit i means responder i. Without a penalty in force, the lowest-numbered responder with intent wins.
- R3: If `rx_ready` is high and `rx_nack` is low during an ask cycle, the data phase starts in the next cycle.
- R4: If `rx_nack` is high during an ask cycle, it overrides `rx_ready`. In that case no data beat follows. The next cycle shows a one-cycle `retry` pulse on the refused responder's bit, and `grant` is zero.
- R5: The data phase lasts exactly 4 consecutive cycles. In each of them `bus_valid` and `snoop_window` are high, `bus_tag` is the granted tag, and `bus_data` equals the granted responder's lane of `data_in` (bits 32i+31..32i).
- R6: `release_valid` pulses for one cycle, in the cycle after the last data beat, with `release_tag` equal to the transferred tag. At that point `grant` is already zero.
- R7: A refused responder ranks below every other requesting responder in the next arbitration round only. If no other responder has intent, it is still granted.
- R8: While the requester has not answered, `ask_valid`, `ask_tag` and `grant` hold.
- R9: After reset, `grant`, `ask_valid`, `bus_valid`, `snoop_window`, `release_valid` and `retry` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| intent | input | NRESP | Per-responder intent to return data |
| intent_tag | input | NRESP*TAG_W | Per-responder tag lanes |
| data_in | input | NRESP*DATA_W | Per-responder data lanes |
| rx_ready | input | 1 | Requester can accept the data |
| rx_nack | input | 1 | Requester refuses, buffer full |
| grant | output | NRESP | One-hot grant to a responder |
| ask_valid | output | 1 | Query to the requester is pending |
| ask_tag | output | TAG_W | Tag of the pending query |
| bus_valid | output | 1 | Data beat strobe |
| bus_data | output | DATA_W | Data on the response bus |
| bus_tag | output | TAG_W | Tag of the data on the bus |
| snoop_window | output | 1 | Other caches present snoop results |
| release_valid | output | 1 | Free the tag's table entry |
| release_tag | output | TAG_W | Tag being freed |
| retry | output | NRESP | One-cycle retry pulse to a refused responder |

## Verification
The assertions check the following on every cycle:
- the grant is one-hot or zero;
- a pending ask holds while the requester is silent;
- a refusal is never followed by a data beat and always produces a retry;
- data can only start right after a ready answer;
- the release carries the tag that was just on the bus.

Only the bench's scenarios can show:
- that the lowest-numbered responder wins;
- that the beat count is exactly four;
- that the data comes from the correct lane;
- that the penalty after a refusal lasts one round and is then forgotten.

// File: rtl/resp_data_arbiter.sv
module resp_data_arbiter #(
  parameter int NRESP  = 4,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NRESP-1:0]        intent,
  input  logic [NRESP*TAG_W-1:0]  intent_tag,
  input  logic [NRESP*DATA_W-1:0] data_in,
  input  logic                    rx_ready,
  input  logic                    rx_nack,
  output logic [NRESP-1:0]        grant,
  output logic                    ask_valid,
  output logic [TAG_W-1:0]        ask_tag,
  output logic                    bus_valid,
  output logic [DATA_W-1:0]       bus_data,
  output logic [TAG_W-1:0]        bus_tag,
  output logic                    snoop_window,
  output logic                    release_valid,
  output logic [TAG_W-1:0]        release_tag,
  output logic [NRESP-1:0]        retry
);
  localparam int IW = (NRESP > 1) ? $clog2(NRESP) : 1;
  localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

  typedef enum logic [2:0] {S_IDLE, S_ASK, S_DATA, S_REL, S_NAK} st_t;

  st_t             st;
  logic [IW-1:0]   gnt_idx, pen_idx, pick_idx;
  logic            pen_vld, pick_vld;
  logic [TAG_W-1:0] gtag;
  logic [CW-1:0]   beat;
  logic [NRESP-1:0] gnt_hot;

  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int i = NRESP - 1; i >= 0; i--)
      if (intent[i] && !(pen_vld && pen_idx == IW'(i))) begin
        pick_vld = 1'b1;
        pick_idx = IW'(i);
      end
    if (!pick_vld && pen_vld && intent[pen_idx]) begin
      pick_vld = 1'b1;
      pick_idx = pen_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      gnt_idx <= '0;
      gtag    <= '0;
      beat    <= '0;
      pen_vld <= 1'b0;
      pen_idx <= '0;
    end else begin
      case (st)
        S_IDLE: if (pick_vld) begin
          st      <= S_ASK;
          gnt_idx <= pick_idx;
          gtag    <= intent_tag[pick_idx*TAG_W +: TAG_W];
          pen_vld <= 1'b0;
        end
        S_ASK: if (rx_nack) begin
          st      <= S_NAK;
          pen_vld <= 1'b1;
          pen_idx <= gnt_idx;
        end else if (rx_ready) begin
          st   <= S_DATA;
          beat <= '0;
        end
        S_DATA: begin
          beat <= beat + 1'b1;
          if (beat == LAST) st <= S_REL;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign gnt_hot       = NRESP'(1) << gnt_idx;
  assign grant         = (st == S_ASK || st == S_DATA) ? gnt_hot : '0;
  assign retry         = (st == S_NAK) ? gnt_hot : '0;
  assign ask_valid     = (st == S_ASK);
  assign ask_tag       = gtag;
  assign bus_valid     = (st == S_DATA);
  assign bus_tag       = gtag;
  assign snoop_window  = bus_valid;
  assign bus_data      = bus_valid ? data_in[gnt_idx*DATA_W +: DATA_W] : '0;
  assign release_valid = (st == S_REL);
  assign release_tag   = gtag;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant)); // R2
  AST_ASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ask_valid && !rx_ready && !rx_nack |=> ask_valid && $stable(grant) && $stable(ask_tag)); // R8
  AST_NACK_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ask_valid && rx_nack |=> !bus_valid && (retry != '0) && (grant == '0)); // R4
  AST_DATA_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> $past(ask_valid && rx_ready && !rx_nack)); // R3
  AST_RELEASE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    release_valid |-> $past(bus_valid) && release_tag == $past(bus_tag) && grant == '0); // R6
  AST_SNOOP_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_window == bus_valid); // R5
endmodule

// File: tb/sim_resp_data_arbiter.sv
module sim_resp_data_arbiter;
  logic clk = 0, rst_n = 0;
  logic [3:0]   intent = 0;
  logic [11:0]  intent_tag = 0;
  logic [127:0] data_in;
  logic rx_ready = 0, rx_nack = 0;
  logic [3:0] grant, retry;
  logic ask_valid, bus_valid, snoop_window, release_valid;
  logic [2:0] ask_tag, bus_tag, release_tag;
  logic [31:0] bus_data;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  resp_data_arbiter u0 (.clk, .rst_n, .intent, .intent_tag, .data_in, .rx_ready, .rx_nack,
    .grant, .ask_valid, .ask_tag, .bus_valid, .bus_data, .bus_tag, .snoop_window,
    .release_valid, .release_tag, .retry);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_tags();
    for (int i = 0; i < 4; i++) begin
      intent_tag[i*3 +: 3] = 3'(i + 4);
      data_in[i*32 +: 32]  = 32'hD000_0000 + 32'(i);
    end
  endtask

  task automatic data_and_release(int idx);
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      chk("R5 bus_valid", 32'(bus_valid), 1);
      chk("R5 snoop", 32'(snoop_window), 1);
      chk("R5 bus_data", bus_data, 32'hD000_0000 + 32'(idx));
      chk("R5 bus_tag", 32'(bus_tag), 32'(idx + 4));
      rx_ready = 0;
    end
    @(negedge clk);
    chk("R6 release", 32'(release_valid), 1);
    chk("R6 tag", 32'(release_tag), 32'(idx + 4));
    chk("R6 grant off", 32'(grant), 0);
    chk("R5 no fifth beat", 32'(bus_valid), 0);
    @(negedge clk);
    chk("R6 one pulse", 32'(release_valid), 0);
  endtask

  task automatic t_reset();
    chk("R9 grant", 32'(grant), 0);
    chk("R9 ask", 32'(ask_valid), 0);
    chk("R9 bus", 32'(bus_valid), 0);
    chk("R9 release", 32'(release_valid), 0);
    chk("R9 retry", 32'(retry), 0);
  endtask

  task automatic t_accept(int idx);
    intent = 4'(1 << idx);
    @(negedge clk);
    chk("R1 grant", 32'(grant), 32'(1 << idx));
    chk("R1 ask", 32'(ask_valid), 1);
    chk("R1 ask_tag", 32'(ask_tag), 32'(idx + 4));
    intent = 0;
    rx_ready = 1;
    data_and_release(idx);
  endtask

  task automatic t_hold();
    intent = 4'b0100;
    @(negedge clk);
    intent = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 ask held", 32'(ask_valid), 1);
      chk("R8 grant held", 32'(grant), 32'b0100);
      chk("R8 no data", 32'(bus_valid), 0);
    end
    rx_ready = 1;
    data_and_release(2);
  endtask

  task automatic t_nack_penalty();
    intent = 4'b0011;
    @(negedge clk);
    chk("R2 lowest wins", 32'(grant), 32'b0001);
    rx_nack = 1;
    rx_ready = 1;
    @(negedge clk);
    rx_nack = 0;
    rx_ready = 0;
    chk("R4 retry", 32'(retry), 32'b0001);
    chk("R4 grant off", 32'(grant), 0);
    chk("R4 no data", 32'(bus_valid), 0);
    @(negedge clk);
    chk("R4 retry one pulse", 32'(retry), 0);
    @(negedge clk);
    chk("R7 penalized loses", 32'(grant), 32'b0010);
    rx_ready = 1;
    data_and_release(1);
    @(negedge clk);
    chk("R7 penalty one round", 32'(grant), 32'b0001);
    intent = 0;
    rx_ready = 1;
    data_and_release(0);
  endtask

  task automatic t_nack_alone();
    intent = 4'b1000;
    @(negedge clk);
    rx_nack = 1;
    @(negedge clk);
    rx_nack = 0;
    chk("R4 retry lane 3", 32'(retry), 32'b1000);
    @(negedge clk);
    @(negedge clk);
    chk("R7 lone penalized granted", 32'(grant), 32'b1000);
    intent = 0;
    rx_ready = 1;
    data_and_release(3);
  endtask

  initial begin
    set_tags();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_accept(0);
    t_accept(3);
    t_hold();
    t_nack_penalty();
    t_nack_alone();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule